// File: doc/BRIEF.md
# Buffered Flash Page-Program Engine

This block sends a serial-flash page-program frame over one data lane: an opcode byte, an address of three or four bytes, and then the data. Software sets up the frame through a small register port. It writes the opcode and the address bytes, picks the address width, and chooses where the data comes from. It then sets a command bit that starts the frame. The command bit reads back as set until the last bit has left the block.

There are two data paths. In staged mode, software fills an internal buffer of 128 bytes with 32-bit writes, and one frame sends the whole buffer. In single-byte mode, the frame carries one data byte taken from a byte register. A configuration bit selects the mode. The hardware acknowledges that bit in readback one cycle after the write, and software polls readback until the new value appears.

Top module: `flash_pp_engine`

## Requirements
- R1: After reset, the command readback (offset 0x000) is 0, the buffer-enable readback (offset 0x064, bit 0) is 0, chip select is high and the serial clock is low.
- R2: A write to offset 0x000 with bit 4 set starts a frame. Bit 4 reads back 1 from the next cycle until the frame ends. It then reads 0 and chip select returns high.
- R3: A frame sends the opcode (offset 0x020) first and then the address bytes, most significant first. Each byte is sent MSB first. The data line is stable at every rising edge of the serial clock and is sampled there (clock idles low).
- R4: Bus-config bit 4 (offset 0x0cc) selects four address bytes: bits 31:24 from offset 0x0c8, then bytes 2,1,0 from offsets 0x018, 0x014 and 0x010. When the bit is clear, only bytes 2,1,0 are sent. A frame therefore has 1 + address bytes + data bytes bytes.
- R5: With the buffer enabled, a frame sends exactly 128 data bytes. These are the staged words in write order, each word sent from bits 7:0 up to bits 31:24. Staging writes go to offset 0x098.
- R6: With the buffer disabled, a frame sends exactly one data byte, taken from offset 0x01c.
- R7: Offset 0x064 bit 0 requests the buffer enable. Its readback follows the written value one cycle after the write, for both enabling and disabling.
- R8: Staging writes after the 32nd word are dropped. The frame still carries the first 32 words.
- R9: The staging write pointer returns to word 0 when a frame completes and when the buffer is disabled. Words that are not rewritten keep their earlier contents.
- R10: A start request made while a frame is in progress is ignored. The running frame keeps its length, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register at reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
The cases hardest to reach from the ports are the staging pointer at its boundaries: a 33rd word arriving at a full buffer, and a partial refill after the pointer has reset. In a partial refill, new words must land at the front and the older tail must still be sent. The stimulus reaches these by staging random words and overflowing the buffer. It refills only five words after a completed frame, and it also stages three words, disables and re-enables the buffer, and stages two more. A bench model of the buffer contents predicts every data byte. A start request issued in the middle of a frame checks that the frame length and the single completion are unchanged.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [11:0] OFS_CMD    = 12'h000;
  localparam logic [11:0] OFS_ADDR0  = 12'h010;
  localparam logic [11:0] OFS_ADDR1  = 12'h014;
  localparam logic [11:0] OFS_ADDR2  = 12'h018;
  localparam logic [11:0] OFS_WBYTE  = 12'h01c;
  localparam logic [11:0] OFS_OPCODE = 12'h020;
  localparam logic [11:0] OFS_CFG    = 12'h064;
  localparam logic [11:0] OFS_STAGE  = 12'h098;
  localparam logic [11:0] OFS_ADDR3  = 12'h0c8;
  localparam logic [11:0] OFS_BUS    = 12'h0cc;
  localparam int CMD_GO_BIT  = 4;
  localparam int BUS_A4_BIT  = 4;

  function automatic int addr_bytes(input logic addr4);
    return addr4 ? 4 : 3;
  endfunction

  // Total serial bits of one frame.
  function automatic int frame_bits(input logic addr4, input logic staged,
                                    input int data_bytes);
    return (1 + addr_bytes(addr4) + (staged ? data_bytes : 1)) * 8;
  endfunction

  // Which staged word holds frame byte idx.
  function automatic int word_sel(input int idx, input logic addr4);
    int na;
    na = addr_bytes(addr4);
    return (idx > na) ? (idx - 1 - na) / 4 : 0;
  endfunction

  // Frame byte idx from the current sources.
  function automatic logic [7:0] pick_byte(input int idx, input logic addr4,
      input logic staged, input logic [7:0] opcode, input logic [31:0] addr,
      input logic [7:0] wbyte, input logic [31:0] word);
    int na;
    na = addr_bytes(addr4);
    if (idx == 0) return opcode;
    if (idx <= na) return 8'(addr >> ((na - idx) * 8));
    if (!staged) return wbyte;
    return 8'(word >> (((idx - 1 - na) % 4) * 8));
  endfunction
endpackage

// File: rtl/pp_stage_buf.sv
module pp_stage_buf #(
  parameter int WORDS = 32,
  parameter int PTR_W = $clog2(WORDS + 1),
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);
  logic [31:0]      mem [WORDS];
  logic [PTR_W-1:0] ptr;
  logic             accept;

  assign accept  = wr_en && (ptr < PTR_W'(WORDS));
  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (clr) ptr <= '0;
      else if (accept) ptr <= ptr + 1'b1;
      if (accept) mem[ptr[IDX_W-1:0]] <= wr_data;
    end
  end

  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(WORDS));
  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0));
endmodule

// File: rtl/pp_regs.sv
module pp_regs
  import pp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        frame_done,
  output logic        start,
  output logic        busy,
  output logic        buf_ack,
  output logic        addr4,
  output logic [7:0]  opcode,
  output logic [31:0] addr,
  output logic [7:0]  wbyte,
  output logic        stage_wr
);
  logic buf_req;

  assign start    = reg_wr && (reg_addr == OFS_CMD) && reg_wdata[CMD_GO_BIT] && !busy;
  assign stage_wr = reg_wr && (reg_addr == OFS_STAGE) && buf_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; buf_req <= 1'b0; buf_ack <= 1'b0; addr4 <= 1'b0;
      opcode <= '0; addr <= '0; wbyte <= '0;
    end else begin
      buf_ack <= buf_req;
      if (start) busy <= 1'b1;
      else if (frame_done) busy <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          OFS_ADDR0:  addr[7:0]   <= reg_wdata[7:0];
          OFS_ADDR1:  addr[15:8]  <= reg_wdata[7:0];
          OFS_ADDR2:  addr[23:16] <= reg_wdata[7:0];
          OFS_ADDR3:  addr[31:24] <= reg_wdata[7:0];
          OFS_WBYTE:  wbyte       <= reg_wdata[7:0];
          OFS_OPCODE: opcode      <= reg_wdata[7:0];
          OFS_CFG:    buf_req     <= reg_wdata[0];
          OFS_BUS:    addr4       <= reg_wdata[BUS_A4_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CMD:    reg_rdata[CMD_GO_BIT] = busy;
      OFS_ADDR0:  reg_rdata[7:0] = addr[7:0];
      OFS_ADDR1:  reg_rdata[7:0] = addr[15:8];
      OFS_ADDR2:  reg_rdata[7:0] = addr[23:16];
      OFS_ADDR3:  reg_rdata[7:0] = addr[31:24];
      OFS_WBYTE:  reg_rdata[7:0] = wbyte;
      OFS_OPCODE: reg_rdata[7:0] = opcode;
      OFS_CFG:    reg_rdata[0]   = buf_ack;
      OFS_BUS:    reg_rdata[BUS_A4_BIT] = addr4;
      default: ;
    endcase
  end

  // R7
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (buf_ack == $past(buf_req)));
  // R2
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(frame_done));
endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
  import pp_pkg::*;
#(
  parameter int DATA_BYTES = 128,
  parameter int IDX_W = $clog2(DATA_BYTES / 4),
  parameter int CNT_W = $clog2((5 + DATA_BYTES) * 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             staged_in,
  input  logic             addr4_in,
  input  logic [7:0]       opcode,
  input  logic [31:0]      addr,
  input  logic [7:0]       wbyte,
  input  logic [31:0]      buf_word,
  output logic [IDX_W-1:0] buf_idx,
  output logic             frame_done,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi
);
  logic             shifting, phase, staged, addr4;
  logic [CNT_W-1:0] bitcnt, last_bit;
  logic [7:0]       cur_byte;
  int               byte_idx;

  assign byte_idx   = int'(bitcnt >> 3);
  assign last_bit   = CNT_W'(frame_bits(addr4, staged, DATA_BYTES) - 1);
  assign buf_idx    = IDX_W'(word_sel(byte_idx, addr4));
  assign cur_byte   = pick_byte(byte_idx, addr4, staged, opcode, addr, wbyte, buf_word);
  assign frame_done = shifting && phase && (bitcnt == last_bit);
  assign spi_cs_n   = !shifting;
  assign spi_sck    = shifting && phase;
  assign spi_mosi   = shifting && cur_byte[3'd7 - bitcnt[2:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifting <= 1'b0; phase <= 1'b0; staged <= 1'b0; addr4 <= 1'b0;
      bitcnt <= '0;
    end else if (start && !shifting) begin
      shifting <= 1'b1; phase <= 1'b0; bitcnt <= '0;
      staged <= staged_in; addr4 <= addr4_in;
    end else if (shifting) begin
      phase <= !phase;
      if (phase) begin
        if (frame_done) shifting <= 1'b0;
        else bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !shifting);
  // R3
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && !phase) |=> (spi_sck && $stable(spi_mosi)));
endmodule

// File: rtl/flash_pp_engine.sv
module flash_pp_engine #(
  parameter int DATA_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi
);
  localparam int WORDS = DATA_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);

  logic             start, busy, buf_ack, addr4, stage_wr, frame_done;
  logic [7:0]       opcode, wbyte;
  logic [31:0]      addr, buf_word;
  logic [IDX_W-1:0] buf_idx;

  pp_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .frame_done, .start, .busy, .buf_ack, .addr4, .opcode, .addr, .wbyte,
    .stage_wr
  );

  pp_stage_buf #(.WORDS(WORDS)) u_buf (
    .clk, .rst_n, .wr_en(stage_wr), .wr_data(reg_wdata),
    .clr(frame_done || !buf_ack), .rd_idx(buf_idx), .rd_word(buf_word)
  );

  pp_sequencer #(.DATA_BYTES(DATA_BYTES)) u_seq (
    .clk, .rst_n, .start, .staged_in(buf_ack), .addr4_in(addr4),
    .opcode, .addr, .wbyte, .buf_word, .buf_idx, .frame_done,
    .spi_sck, .spi_cs_n, .spi_mosi
  );

  // R2
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
endmodule

// File: tb/flash_pp_engine_tb.sv
module flash_pp_engine_tb;
  localparam int PERIOD = 10;
  localparam int NW = 32;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;

  int checks = 0, failures = 0;
  logic [31:0] mdl [NW];
  int mptr = 0;
  logic men = 0;
  logic [7:0] m_op = 0, m_wb = 0;
  logic [31:0] m_addr = 0;
  logic m_a4 = 0;
  logic [7:0] cap [256];
  int cap_n = 0;
  logic prev_sck = 0;

  flash_pp_engine u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!spi_cs_n && spi_sck && !prev_sck) begin
      cap[(cap_n / 8) % 256] = {cap[(cap_n / 8) % 256][6:0], spi_mosi};
      cap_n = cap_n + 1;
    end
    prev_sck = spi_sck;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic set_en(input logic e);
    logic [31:0] v;
    wr(12'h064, {31'd0, e});
    @(negedge clk); reg_addr = 12'h064; #1 v = reg_rdata;
    chk("R7", v, {31'd0, e});
    men = e;
    if (!e) mptr = 0;
  endtask

  task automatic stage(input logic [31:0] w);
    wr(12'h098, w);
    if (men) begin
      if (mptr < NW) mdl[mptr] = w;
      if (mptr < NW) mptr++;
    end
  endtask

  task automatic setup(input logic [7:0] op, input logic [31:0] a, input logic a4,
                       input logic [7:0] wb);
    wr(12'h020, {24'd0, op}); wr(12'h010, {24'd0, a[7:0]});
    wr(12'h014, {24'd0, a[15:8]}); wr(12'h018, {24'd0, a[23:16]});
    wr(12'h0c8, {24'd0, a[31:24]}); wr(12'h0cc, {27'd0, a4, 4'd0});
    wr(12'h01c, {24'd0, wb});
    m_op = op; m_addr = a; m_a4 = a4; m_wb = wb;
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    int na;
    na = m_a4 ? 4 : 3;
    if (k == 0) return m_op;
    if (k <= na) return 8'(m_addr >> ((na - k) * 8));
    if (!men) return m_wb;
    return 8'(mdl[(k - 1 - na) / 4] >> (((k - 1 - na) % 4) * 8));
  endfunction

  task automatic frame(input string req, input logic poke);
    int base, nbytes, bad, wait_n;
    logic [31:0] v;
    nbytes = 1 + (m_a4 ? 4 : 3) + (men ? 128 : 1);
    base = cap_n;
    wr(12'h000, 32'h10);
    rd(12'h000, v);
    chk("R2 busy after start", v, 32'h10);
    if (poke) begin
      repeat (40) @(negedge clk);
      wr(12'h000, 32'h10);
    end
    wait_n = 0;
    v = 32'h10;
    while (v != 0 && wait_n < 5000) begin rd(12'h000, v); wait_n++; end
    chk("R2 busy cleared", v, 0);
    chk("R2 cs high", {31'd0, spi_cs_n}, 1);
    repeat (20) @(negedge clk);
    chk({req, " frame bits"}, cap_n - base, nbytes * 8);
    bad = 0;
    for (int k = 0; k < nbytes; k++)
      if (bad == 0 && cap[(base / 8 + k) % 256] !== exp_byte(k)) begin
        bad = 1;
        chk({req, " byte"}, cap[(base / 8 + k) % 256], exp_byte(k));
      end
    if (bad == 0) chk({req, " bytes"}, 0, 0);
    if (men) mptr = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(12'h000, v); chk("R1 cmd", v, 0);
    rd(12'h064, v); chk("R1 ack", v, 0);
    chk("R1 cs", {31'd0, spi_cs_n}, 1);
    chk("R1 sck", {31'd0, spi_sck}, 0);
    // R7 timing: ack appears one cycle after the write
    @(negedge clk); reg_wr = 1; reg_addr = 12'h064; reg_wdata = 1;
    @(negedge clk); reg_wr = 0; #1 chk("R7 not yet", reg_rdata, 0);
    @(negedge clk); #1 chk("R7 set", reg_rdata, 1);
    men = 1;
    // R5 R3: staged, three address bytes
    setup(8'h02, 32'h00A1B2C3, 0, 8'h5A);
    for (int i = 0; i < NW; i++) stage($urandom);
    frame("R5 R3", 0);
    // R4: four address bytes
    setup(8'h12, 32'h9876_5432, 1, 8'h00);
    for (int i = 0; i < NW; i++) stage($urandom);
    frame("R4", 0);
    // R8: 33rd word dropped
    for (int i = 0; i < NW + 1; i++) stage($urandom);
    frame("R8", 0);
    // R9: partial refill after a frame
    for (int i = 0; i < 5; i++) stage($urandom);
    frame("R9 after frame", 0);
    // R9: disable/enable resets pointer
    for (int i = 0; i < 3; i++) stage($urandom);
    set_en(0); set_en(1);
    for (int i = 0; i < 2; i++) stage($urandom);
    frame("R9 after disable", 0);
    // R10: start while busy
    frame("R10", 1);
    // R6: single byte, both address widths
    set_en(0);
    setup(8'h02, 32'h0012_3456, 0, 8'hC3);
    frame("R6 a3", 0);
    setup(8'h12, 32'hFEDC_BA98, 1, 8'h81);
    frame("R6 a4", 0);
    // random mix
    for (int n = 0; n < 6; n++) begin
      set_en(1'($urandom));
      setup(8'($urandom), $urandom, 1'($urandom), 8'($urandom));
      for (int i = 0; i < int'($urandom % 36); i++) stage($urandom);
      frame("R3 R4 R5 R6 random", 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule